// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

A single-port synchronous static memory with a flow-through read path. The address is registered on the rising clock edge, and the addressed word appears on the output in the same cycle, with no output register after the array. A two-bit burst counter takes over the two low address bits after an access starts. The upper bits stay fixed, and the advance input steps the counter through four beats in either a linear or an interleaved order.

Two strobes can start an access. The processor strobe counts only while the first chip select is active, and its first cycle is always a read. The controller strobe always starts an access, and it applies the write controls of its own cycle. Writes go to all byte lanes under the global write enable, or to a chosen set of lanes under the byte-write enable. There are three synchronous chip selects, an asynchronous output enable and a sleep input.

The shared data bus is modelled as an input, an output and a drive-enable, which a pad ring combines into one bidirectional bus.

Top module: `sync_burst_sram`

## Requirements
- R1: On a clock edge where an access starts, the registered address is the `addr_i` sampled at that edge. When the part is selected and `oe` is high, the word at that address appears on `dq_o` in the cycle right after that edge.
- R2: With `mode` low, beat k of a burst that starts at low index s uses low address bits (s + k) mod 4.
- R3: With `mode` high, beat k of a burst that starts at low index s uses low address bits s XOR k.
- R4: On an edge with `adv` high and no accepted strobe, the counter steps one beat; after the fourth beat it returns to s. With `adv` low and no accepted strobe, the address holds. The upper address bits never change inside a burst.
- R5: `gwe` high writes all four lanes on a write cycle, whatever `bwe` and `bsel` hold.
- R6: With `gwe` low and `bwe` high, only the lanes whose `bsel` bit is 1 are written. Bit i of `bsel` controls data bits 8i+7..8i. With `bsel` all zero, or with `bwe` and `gwe` both low, the cycle is a read and the memory is unchanged.
- R7: An access is selected only if `cs1`, `cs2` and `cs3` are all high at the starting edge. A deselected access writes nothing and keeps `dq_oe` low.
- R8: `dq_oe` is low whenever `oe` is low. This follows `oe` without waiting for a clock edge.
- R9: A processor strobe while `cs1` is low is ignored. The edge acts as if the strobe were absent, so with `adv` high the burst advances.
- R10: The first cycle of an access started by the processor strobe writes nothing, even with `gwe` or `bwe` high. The processor strobe has priority when both strobes are high.
- R11: The controller strobe starts an access even with `cs1` low, which gives a deselected access. With all selects high it applies the write controls sampled at that edge to the new address.
- R12: While `sleep` is high, the block ignores strobes, advance and write controls, keeps its state and memory, and holds `dq_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| pstrb | input | 1 | Processor address strobe, active high |
| cstrb | input | 1 | Controller address strobe, active high |
| adv | input | 1 | Burst advance |
| mode | input | 1 | 1 selects interleaved order, 0 selects linear order |
| cs1 | input | 1 | Chip select 1, which also qualifies the processor strobe |
| cs2 | input | 1 | Chip select 2 |
| cs3 | input | 1 | Chip select 3 |
| gwe | input | 1 | Global write enable |
| bwe | input | 1 | Byte-write enable |
| bsel | input | LANES | Per-lane write select |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep, which suspends all activity |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a processor strobe that arrives in the middle of a burst while the first chip select is low. It looks like a restart but must count as a plain advance. The bench starts an interleaved burst, presents the processor strobe with `cs1` low, `adv` high and a different address, and checks that the next interleaved beat appears instead of the new address. Sleep is handled the same way: strobes and write controls are asserted during the sleep cycle, and the bench then shows that both the burst position and the memory contents came through unchanged.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Burst index for beat k from start index s.
  function automatic logic [1:0] beat_index(input logic [1:0] s,
                                            input logic [1:0] k,
                                            input logic interleave);
    return interleave ? (s ^ k) : (s + k);
  endfunction
endpackage

// File: rtl/sbs_addr_ctr.sv
module sbs_addr_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pstrb,
  input  logic              cstrb,
  input  logic              adv,
  input  logic              cs_all,
  input  logic              cs1,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              sel_q,
  output logic              p_go,
  output logic              c_go
);
  import sbs_pkg::*;
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q, beat_q;
  logic            start_go, step;

  assign p_go     = pstrb & cs1 & ~sleep;
  assign c_go     = cstrb & ~sleep;
  assign start_go = p_go | c_go;
  assign step     = ~sleep & ~start_go & adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
      sel_q   <= 1'b0;
    end else if (start_go) begin
      hi_q    <= addr_i[ADDR_W-1:2];
      start_q <= addr_i[1:0];
      beat_q  <= 2'd0;
      sel_q   <= cs_all;
    end else if (step) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign cur_addr = {hi_q, beat_index(start_q, beat_q, mode)};

  // R1
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> cur_addr == $past(addr_i));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_go && !adv) |=> $stable({hi_q, start_q, beat_q}));
  // R4
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(hi_q) && beat_q == $past(beat_q) + 2'd1);
  // R9
  pstrb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstrb && !cs1 && !cstrb && !sleep && adv) |=> $stable(hi_q) && $stable(start_q));
  // R12
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable({hi_q, start_q, beat_q, sel_q}));
endmodule

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             gwe,
  input  logic             bwe,
  input  logic [LANES-1:0] bsel,
  output logic [LANES-1:0] lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i] = gwe | (bwe & bsel[i]);
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) bank[waddr] <= wdata[i*LANE_W +: LANE_W];
    end
    assign rdata[i*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pstrb,
  input  logic              cstrb,
  input  logic              adv,
  input  logic              mode,
  input  logic              cs1,
  input  logic              cs2,
  input  logic              cs3,
  input  logic              gwe,
  input  logic              bwe,
  input  logic [LANES-1:0]  bsel,
  input  logic              oe,
  input  logic              sleep,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  logic [ADDR_W-1:0] cur_addr, waddr;
  logic              sel_q, p_go, c_go, cs_all, wr_ok;
  logic [LANES-1:0]  lanes, we;

  assign cs_all = cs1 & cs2 & cs3;

  sbs_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .mode(mode), .addr_i(addr_i),
    .pstrb(pstrb), .cstrb(cstrb), .adv(adv), .cs_all(cs_all), .cs1(cs1),
    .cur_addr(cur_addr), .sel_q(sel_q), .p_go(p_go), .c_go(c_go)
  );

  sbs_lane_dec #(.LANES(LANES)) u_dec (
    .gwe(gwe), .bwe(bwe), .bsel(bsel), .lanes(lanes)
  );

  // Write only with no sleep and no processor start, and then either on a
  // selected controller start or on a continuation of a selected access.
  assign wr_ok = ~sleep & ~p_go & ((c_go & cs_all) | (~c_go & sel_q));
  assign we    = lanes & {LANES{wr_ok}};
  assign waddr = c_go ? addr_i : cur_addr;

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(dq_i),
    .raddr(cur_addr), .rdata(dq_o)
  );

  assign dq_oe = sel_q & oe & ~sleep;

  // R10
  pstrb_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_go |-> we == '0);
  // R7
  desel_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_go && !c_go && !sel_q) |-> we == '0);
  // R5
  gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gwe && c_go && !p_go && cs_all) |-> &we);
  // R12
  sleep_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> we == '0);
  // R8
  always_comb begin
    if (rst_n && !oe) oe_gate_chk: assert (!dq_oe);
  end
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr_i;
  logic pstrb, cstrb, adv, mode, cs1, cs2, cs3, gwe, bwe, oe, sleep;
  logic [3:0] bsel;
  logic [DW-1:0] dq_i, dq_o;
  logic dq_oe;

  int checks = 0, failures = 0;
  logic [DW-1:0] model [64];

  always #4 clk = ~clk;

  sync_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .pstrb(pstrb), .cstrb(cstrb),
    .adv(adv), .mode(mode), .cs1(cs1), .cs2(cs2), .cs3(cs3), .gwe(gwe),
    .bwe(bwe), .bsel(bsel), .oe(oe), .sleep(sleep), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input int a);
    logic [7:0] b = 8'(a);
    return {b, ~b, b ^ 8'h5A, b + 8'h33};
  endfunction

  // Own restatement of the burst order.
  function automatic int order(input int s, input int k, input logic il);
    if (il) return (s ^ k) & 3;
    return (s + k) % 4;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pstrb = 0; cstrb = 0; adv = 0; cs1 = 1; cs2 = 1; cs3 = 1;
    gwe = 0; bwe = 0; bsel = 0; oe = 1; sleep = 0; dq_i = '0; addr_i = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic cwrite(input int a, input logic [DW-1:0] d, input logic g,
                        input logic b, input logic [3:0] s);
    idle(); cstrb = 1; addr_i = AW'(a); dq_i = d; gwe = g; bwe = b; bsel = s;
    tick();
  endtask

  task automatic t_reset();
    chk(dq_oe == 1'b0, "R7 reset deselected", {31'd0, dq_oe}, 0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 64; a++) begin
      cwrite(a, pat(a), 1, 0, 4'h0);
      model[a] = pat(a);
    end
    chk(dq_oe && dq_o == pat(63), "R1 R11 write then flow-through", dq_o, pat(63));
  endtask

  task automatic t_burst(input logic il, input int s);
    int base = 16;
    idle(); mode = il; pstrb = 1; addr_i = AW'(base + s);
    tick();
    chk(dq_o == model[base + s], "R1 first beat", dq_o, model[base + s]);
    idle(); mode = il; adv = 1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk(dq_o == model[base + order(s, k % 4, il)],
          il ? "R3 interleaved beat" : "R2 linear beat (R4 wrap)",
          dq_o, model[base + order(s, k % 4, il)]);
    end
    idle(); mode = il;
    tick();
    chk(dq_o == model[base + s], "R4 hold without adv", dq_o, model[base + s]);
  endtask

  task automatic t_bytes();
    logic [DW-1:0] d = 32'hA1B2C3D4;
    cwrite(5, d, 0, 1, 4'b0101);
    model[5] = {model[5][31:24], d[23:16], model[5][15:8], d[7:0]};
    chk(dq_o == model[5], "R6 partial lanes", dq_o, model[5]);
    cwrite(6, d, 0, 1, 4'b0000);
    chk(dq_o == model[6], "R6 empty select is read", dq_o, model[6]);
    cwrite(7, d, 0, 0, 4'b1111);
    chk(dq_o == model[7], "R6 no enables is read", dq_o, model[7]);
    cwrite(8, d, 1, 1, 4'b0000);
    model[8] = d;
    chk(dq_o == d, "R5 global overrides lanes", dq_o, d);
  endtask

  task automatic t_cs();
    idle(); cstrb = 1; cs2 = 0; gwe = 1; addr_i = 20; dq_i = 32'hDEAD0001;
    tick();
    chk(dq_oe == 0, "R7 cs2 low deselects", {31'd0, dq_oe}, 0);
    idle(); cstrb = 1; cs3 = 0; gwe = 1; addr_i = 21; dq_i = 32'hDEAD0002;
    tick();
    idle(); cstrb = 1; cs1 = 0; gwe = 1; addr_i = 22; dq_i = 32'hDEAD0003;
    tick();
    chk(dq_oe == 0, "R11 cstrb with cs1 low deselects", {31'd0, dq_oe}, 0);
    for (int a = 20; a <= 22; a++) begin
      idle(); pstrb = 1; addr_i = AW'(a);
      tick();
      chk(dq_o == model[a], "R7 deselected write ignored", dq_o, model[a]);
    end
  endtask

  task automatic t_oe();
    idle(); pstrb = 1; addr_i = 3;
    tick();
    oe = 0; #1;
    chk(dq_oe == 0, "R8 oe low async", {31'd0, dq_oe}, 0);
    oe = 1; #1;
    chk(dq_oe == 1, "R8 oe high drives", {31'd0, dq_oe}, 1);
  endtask

  task automatic t_pstrb_cs1();
    idle(); mode = 1; pstrb = 1; addr_i = 12 + 2;
    tick();
    idle(); mode = 1; pstrb = 1; cs1 = 0; adv = 1; addr_i = 40;
    tick();
    chk(dq_o == model[12 + order(2, 1, 1)], "R9 ignored pstrb advances",
        dq_o, model[12 + order(2, 1, 1)]);
  endtask

  task automatic t_pstrb_write();
    idle(); pstrb = 1; gwe = 1; bwe = 1; bsel = 4'hF; addr_i = 30;
    dq_i = 32'hBADC0FFE;
    tick();
    chk(dq_o == model[30], "R10 pstrb first cycle read", dq_o, model[30]);
    idle(); pstrb = 1; cstrb = 1; gwe = 1; addr_i = 31; dq_i = 32'hBADC0FFE;
    tick();
    chk(dq_o == model[31], "R10 pstrb priority no write", dq_o, model[31]);
  endtask

  task automatic t_sleep();
    idle(); pstrb = 1; addr_i = 9;
    tick();
    idle(); sleep = 1; cstrb = 1; gwe = 1; adv = 1; addr_i = 10;
    dq_i = 32'h5EE95EE9;
    tick();
    chk(dq_oe == 0, "R12 sleep bus off", {31'd0, dq_oe}, 0);
    idle();
    tick();
    chk(dq_oe && dq_o == model[9], "R12 state kept", dq_o, model[9]);
    idle(); pstrb = 1; addr_i = 10;
    tick();
    chk(dq_o == model[10], "R12 memory kept", dq_o, model[10]);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(); mode = 0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1;
    tick();
    t_fill();
    for (int s = 0; s < 4; s++) t_burst(0, s);
    for (int s = 0; s < 4; s++) t_burst(1, s);
    t_bytes();
    t_cs();
    t_oe();
    t_pstrb_cs1();
    t_pstrb_write();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule